// File: doc/BRIEF.md
# Qualified Peripheral Chip-Select Decoder

This block turns a 24-bit processor address into three active-low chip selects: one for a read-sensitive serial peripheral, one for a ROM region and one for a RAM region. The processor marks each bus cycle with two flags. One says the address is a genuine data access. The other says it is a genuine program fetch. When qualification is enabled, a select can go low only in a cycle where at least one flag is high. Dummy reads of indexed addressing, internal cycles and the throw-away write of a read-modify-write therefore never reach the peripheral. All selects are also gated by the phase-2 clock, so they are valid only in the data phase.

A strap input turns qualification off. The selects then follow the address and phase-2 only, as they would on a bus without qualification flags. A built-in monitor samples the peripheral select once per bus cycle on the block clock, which runs at one edge per bus cycle. It sets a sticky violation flag when the peripheral is selected in two consecutive bus cycles, because the peripheral forbids that timing. A synchronous active-high reset clears the monitor.

Top module: `qual_cs_decoder`

## Requirements
- R1: `per_cs_n` is low exactly when `addr` lies in 0x00D100..0x00D1FF, `phi2` is high and the cycle is qualified.
- R2: `rom_cs_n` is low exactly when `addr` lies in 0x00E000..0x00FFFF, `phi2` is high and the cycle is qualified.
- R3: `ram_cs_n` is low exactly when `addr` lies in 0x000000..0x00CFFF, `phi2` is high and the cycle is qualified. Addresses 0x00D000..0x00D0FF, 0x00D200..0x00DFFF and 0x010000 and above assert no select.
- R4: With `qual_en`=1 a cycle counts as qualified only if `vda` or `vpa` is 1. When both are 0, all three selects stay high, including for the dummy cycle of an indexed store and for the modify-cycle write of a read-modify-write.
- R5: When `phi2` is 0, all three selects are high whatever the other inputs are.
- R6: With `qual_en`=0 every cycle counts as qualified, so `vda` and `vpa` have no effect on the selects.
- R7: The monitor samples `per_cs_n` at each rising edge of `clk`. If the sample is low in two consecutive edges, `b2b_viol` becomes 1 after the second edge and stays 1 until reset.
- R8: While `rst` is 1 at a rising edge of `clk`, `b2b_viol` becomes 0 and the stored previous sample is cleared. A peripheral access in the first cycle after reset alone does not set the flag.
- R9: At most one of the three selects is low at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Monitor clock, one rising edge per bus cycle |
| rst | input | 1 | Synchronous active-high reset of the monitor |
| qual_en | input | 1 | 1: gate selects with the cycle flags; 0: ignore the flags |
| phi2 | input | 1 | Phase-2 bus clock; selects are valid only while it is high |
| addr | input | 24 | Processor address |
| rw | input | 1 | Read (1) / write (0) strobe; passed to the devices, not used in decoding |
| vda | input | 1 | Cycle carries a valid data address |
| vpa | input | 1 | Cycle carries a valid program address |
| per_cs_n | output | 1 | Active-low peripheral select |
| rom_cs_n | output | 1 | Active-low ROM select |
| ram_cs_n | output | 1 | Active-low RAM select |
| b2b_viol | output | 1 | Sticky flag: peripheral selected in consecutive bus cycles |

## Verification
A vector table sweeps the addresses on both sides of every region boundary. The bench uses each flag combination, with qualification on and off and with phase-2 low. This separates decoding errors from gating errors. Two recorded traces then run in both configurations. The first is an indexed store into the peripheral with no page carry, where the dummy address equals the target. The second is a read-modify-write into the peripheral page. With qualification on, the violation flag must stay clear; with it off, the flag must set. Reset and a lone access right after reset check that the flag clears and does not fire falsely.

// File: rtl/cs_pkg.sv
package cs_pkg;
  localparam int ADDR_W = 24;
  localparam int NREG   = 3;
  typedef enum logic [1:0] {RG_RAM = 2'd0, RG_ROM = 2'd1, RG_PER = 2'd2} region_e;
endpackage

// File: rtl/cs_range_match.sv
module cs_range_match #(
  parameter int          AW = 24,
  parameter logic [23:0] LO = '0,
  parameter logic [23:0] HI = '0
) (
  input  logic [AW-1:0] addr,
  output logic          hit
);
  localparam logic [AW-1:0] SPAN = AW'(HI - LO);
  logic [AW-1:0] offs;
  // one subtract and one compare: an address below LO wraps to a large offset
  always_comb begin
    offs = addr - AW'(LO);
    hit  = (offs <= SPAN);
  end
endmodule

// File: rtl/cs_qualify.sv
module cs_qualify #(
  parameter int N = 3
) (
  input  logic         qual_en,
  input  logic         phi2,
  input  logic         vda,
  input  logic         vpa,
  input  logic [N-1:0] hit,
  output logic [N-1:0] sel
);
  logic genuine;
  always_comb begin
    genuine = !qual_en || vda || vpa;
    sel     = hit & {N{genuine && phi2}};
  end
endmodule

// File: rtl/cs_b2b_monitor.sv
module cs_b2b_monitor (
  input  logic clk,
  input  logic rst,
  input  logic access,
  output logic viol
);
  logic prev_q, viol_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      viol_q <= 1'b0;
    end else begin
      prev_q <= access;
      viol_q <= viol_q | (access & prev_q);
    end
  end
  assign viol = viol_q;

  p_viol_set_r7: assert property (@(posedge clk) disable iff (rst)
    (access && prev_q) |=> viol);
  p_viol_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    viol |=> viol);
  p_reset_clear_r8: assert property (@(posedge clk)
    rst |=> (!viol && !prev_q));
endmodule

// File: rtl/qual_cs_decoder.sv
module qual_cs_decoder #(
  parameter logic [23:0] PER_LO = 24'h00D100,
  parameter logic [23:0] PER_HI = 24'h00D1FF,
  parameter logic [23:0] ROM_LO = 24'h00E000,
  parameter logic [23:0] ROM_HI = 24'h00FFFF,
  parameter logic [23:0] RAM_LO = 24'h000000,
  parameter logic [23:0] RAM_HI = 24'h00CFFF
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        qual_en,
  input  logic        phi2,
  input  logic [23:0] addr,
  input  logic        rw,
  input  logic        vda,
  input  logic        vpa,
  output logic        per_cs_n,
  output logic        rom_cs_n,
  output logic        ram_cs_n,
  output logic        b2b_viol
);
  import cs_pkg::*;

  localparam logic [23:0] LO_T [NREG] = '{RAM_LO, ROM_LO, PER_LO};
  localparam logic [23:0] HI_T [NREG] = '{RAM_HI, ROM_HI, PER_HI};

  logic [NREG-1:0] hit, sel;
  logic            rw_unused;
  assign rw_unused = rw;

  for (genvar g = 0; g < NREG; g++) begin : g_rng
    cs_range_match #(.AW(ADDR_W), .LO(LO_T[g]), .HI(HI_T[g])) u_rng (
      .addr (addr),
      .hit  (hit[g])
    );
  end

  cs_qualify #(.N(NREG)) u_q (
    .qual_en (qual_en),
    .phi2    (phi2),
    .vda     (vda),
    .vpa     (vpa),
    .hit     (hit),
    .sel     (sel)
  );

  assign per_cs_n = ~sel[RG_PER];
  assign rom_cs_n = ~sel[RG_ROM];
  assign ram_cs_n = ~sel[RG_RAM];

  cs_b2b_monitor u_mon (
    .clk    (clk),
    .rst    (rst),
    .access (~per_cs_n),
    .viol   (b2b_viol)
  );

  p_onehot_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({~per_cs_n, ~rom_cs_n, ~ram_cs_n}));
  p_unqual_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    (qual_en && !vda && !vpa) |-> (per_cs_n && rom_cs_n && ram_cs_n));
  p_phi2_low_r5: assert property (@(posedge clk) disable iff (rst)
    !phi2 |-> (per_cs_n && rom_cs_n && ram_cs_n));
  p_per_page_r1: assert property (@(posedge clk) disable iff (rst)
    !per_cs_n |-> (addr[23:8] == 16'h00D1));
endmodule

// File: tb/sim_qual_cs_decoder.sv
module sim_qual_cs_decoder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        qual_en = 1'b1, phi2 = 1'b1, rw = 1'b1, vda = 1'b0, vpa = 1'b0;
  logic [23:0] addr = '0;
  logic        per_cs_n, rom_cs_n, ram_cs_n, b2b_viol;
  int          n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  qual_cs_decoder u0 (
    .clk(clk), .rst(rst), .qual_en(qual_en), .phi2(phi2), .addr(addr),
    .rw(rw), .vda(vda), .vpa(vpa), .per_cs_n(per_cs_n),
    .rom_cs_n(rom_cs_n), .ram_cs_n(ram_cs_n), .b2b_viol(b2b_viol)
  );

  // {qual_en, vda, vpa, phi2, addr[23:0], per, rom, ram} with select active = 1
  localparam int NV = 18;
  localparam logic [30:0] VEC [NV] = '{
    {4'b1101, 24'h00D100, 3'b100},  // R1 lower edge
    {4'b1101, 24'h00D1FF, 3'b100},  // R1 upper edge
    {4'b1011, 24'h00D155, 3'b100},  // R1 program flag
    {4'b1101, 24'h00D0FF, 3'b000},  // R3 gap below page
    {4'b1101, 24'h00D200, 3'b000},  // R3 gap above page
    {4'b1101, 24'h00DFFF, 3'b000},  // R3 gap
    {4'b1101, 24'h00E000, 3'b010},  // R2 lower edge
    {4'b1011, 24'h00FFFF, 3'b010},  // R2 upper edge
    {4'b1101, 24'h010000, 3'b000},  // R3 above 64K
    {4'b1101, 24'h000000, 3'b001},  // R3 lower edge
    {4'b1111, 24'h00CFFF, 3'b001},  // R3 upper edge
    {4'b1001, 24'h00D100, 3'b000},  // R4 unqualified peripheral
    {4'b1001, 24'h00E123, 3'b000},  // R4 unqualified rom
    {4'b1001, 24'h001234, 3'b000},  // R4 unqualified ram
    {4'b1110, 24'h00D100, 3'b000},  // R5 phi2 low
    {4'b0000, 24'h00E000, 3'b000},  // R5 phi2 low, ungated
    {4'b0001, 24'h00D1AA, 3'b100},  // R6 flags ignored
    {4'b0001, 24'h004000, 3'b001}   // R6 flags ignored
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic [23:0] a, input logic w, input logic d, input logic p);
    @(negedge clk);
    addr = a; rw = w; vda = d; vpa = p;
  endtask

  // indexed store to peripheral: opcode fetch, two operand bytes, dummy read, real write
  task automatic trace_store();
    cyc(24'h00F00C, 1'b1, 1'b1, 1'b1);
    cyc(24'h00F00D, 1'b1, 1'b0, 1'b1);
    cyc(24'h00F00E, 1'b1, 1'b0, 1'b1);
    cyc(24'h00D102, 1'b1, 1'b0, 1'b0);
    cyc(24'h00D102, 1'b0, 1'b1, 1'b0);
    cyc(24'h00F00F, 1'b1, 1'b1, 1'b1);
  endtask

  // read-modify-write into peripheral page: read, modify write with flag low, real write
  task automatic trace_rmw();
    cyc(24'h00F010, 1'b1, 1'b1, 1'b1);
    cyc(24'h00F011, 1'b1, 1'b0, 1'b1);
    cyc(24'h00F012, 1'b1, 1'b0, 1'b1);
    cyc(24'h00D0F4, 1'b1, 1'b0, 1'b0);
    cyc(24'h00D1F4, 1'b1, 1'b1, 1'b0);
    cyc(24'h00D1F4, 1'b0, 1'b0, 1'b0);
    cyc(24'h00D1F4, 1'b0, 1'b1, 1'b0);
    cyc(24'h00F013, 1'b1, 1'b1, 1'b1);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; addr = 24'h000100; vda = 1'b0; vpa = 1'b0;
    @(negedge clk); rst = 1'b0;
  endtask

  initial begin : wdog
    #1000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    #1;
    chk("R8 reset flag", 32'(b2b_viol), 0);
    chk("R4 reset selects", {29'd0, per_cs_n, rom_cs_n, ram_cs_n}, 32'h7);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {qual_en, vda, vpa, phi2, addr} = VEC[i][30:3];
      #1;
      chk($sformatf("R1/R2/R3/R4/R5/R6 vec %0d", i),
          {29'd0, ~per_cs_n, ~rom_cs_n, ~ram_cs_n}, {29'd0, VEC[i][2:0]});
    end

    // traces with qualification on
    phi2 = 1'b1; qual_en = 1'b1;
    do_reset();
    trace_store();
    @(negedge clk); #1;
    chk("R4 qualified store no viol", 32'(b2b_viol), 0);
    trace_rmw();
    @(negedge clk); #1;
    chk("R4 qualified rmw no viol", 32'(b2b_viol), 0);

    // dummy cycle selects nothing while qualified
    @(negedge clk); addr = 24'h00D102; vda = 1'b0; vpa = 1'b0; #1;
    chk("R4 dummy equal address", 32'(per_cs_n), 1);

    // unqualified store trace
    qual_en = 1'b0;
    do_reset();
    trace_store();
    @(negedge clk); #1;
    chk("R7 unqualified store viol", 32'(b2b_viol), 1);
    repeat (3) cyc(24'h000200, 1'b1, 1'b1, 1'b0);
    #1;
    chk("R7 flag sticky", 32'(b2b_viol), 1);

    do_reset();
    #1;
    chk("R8 reset clears flag", 32'(b2b_viol), 0);
    trace_rmw();
    @(negedge clk); #1;
    chk("R7 unqualified rmw viol", 32'(b2b_viol), 1);

    // single access right after reset, then gap, then single access
    qual_en = 1'b1;
    @(negedge clk); rst = 1'b1; addr = 24'h00D100; vda = 1'b1;
    @(negedge clk); rst = 1'b0; addr = 24'h00D101; vda = 1'b1;
    @(negedge clk); addr = 24'h00E000;
    @(negedge clk); addr = 24'h00D101;
    @(negedge clk); addr = 24'h000000; #1;
    chk("R8 access after reset alone", 32'(b2b_viol), 0);

    // back-to-back qualified accesses also flagged
    cyc(24'h00D110, 1'b1, 1'b1, 1'b0);
    cyc(24'h00D111, 1'b1, 1'b1, 1'b0);
    cyc(24'h000000, 1'b1, 1'b1, 1'b0);
    #1;
    chk("R7 qualified consecutive", 32'(b2b_viol), 1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule